// File: doc/BRIEF.md
# Gray-Coded Serial Hit Frame Transmitter

This block turns each accepted hit into a short fixed-length serial frame on a single line. The frame contains a start marker, a small slice of a free-running Gray-coded coarse counter, and the fine interpolation code that came with the hit. The full timestamp is never sent. The receiver keeps its own copy of the coarse counter, clocked from the same reference. It rebuilds the full time from the Gray slice, so each hit costs only a few bits on the wire.

The line is clocked on the reference clock edge, which keeps the two counters matched. Only one frame is on the line at a time. A new frame may start on the edge that ends the previous one, so with the default widths one line can carry one hit every ten clock cycles. A hit that arrives while a frame is still being sent is discarded and reported on a one-cycle flag. The number of coarse bits in the frame is a parameter, which trades line occupancy against the time range that can be recovered without ambiguity.

Top module: `gray_hit_serializer`

## Requirements
- R1: While no frame is being sent, `ser_o` is 0, both after reset and between frames.
- R2: In the clock cycle after the edge that accepts a hit, `ser_o` is 1 (the start bit). The frame then lasts exactly 1 + GRAY_W + FINE_W cycles, which is 10 cycles with the defaults.
- R3: The GRAY_W bits that follow the start bit are the low GRAY_W bits of the Gray code (g = b ^ (b >> 1)) of a binary counter. The counter is 0 in the first cycle after reset is released and counts up by one each clock. The value sent is the one present in the cycle in which the hit is sampled, most significant bit first.
- R4: The last FINE_W bits of the frame are `fine_i` as sampled on the accepting edge, most significant bit first.
- R5: A hit sampled while a frame is in progress, other than in its last bit cycle, is dropped. It does not alter the frame on the line, and `lost_o` is 1 for exactly the following cycle. `lost_o` is 0 otherwise.
- R6: A hit sampled in the last bit cycle of a frame is accepted, and its start bit follows the previous frame's last bit with no idle cycle.
- R7: A synchronous active-high `rst` aborts any frame in progress. It forces `ser_o` and `lost_o` to 0 and restarts the coarse counter, so the next frame carries the Gray code of the cycle count since that reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; line bit clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_i | input | 1 | Hit strobe, sampled on each rising edge |
| fine_i | input | FINE_W (5) | Fine interpolator code of the hit |
| ser_o | output | 1 | Serial frame line |
| lost_o | output | 1 | One-cycle pulse after a dropped hit |

## Verification
A coarse counter that skipped or stalled would not show at once. It would appear on the next frame as Gray bits that disagree with a count of cycles since reset, and every later frame would carry the same error. A bit counter or shift register in the wrong state shows within one frame: a missing start bit, a frame of the wrong length, a line that stays high when idle, or a back-to-back frame that has a gap or overlaps the previous one. An acceptance window in the wrong place shows on the cycle after the hit, as a `lost_o` pulse or a corrupted frame on the line.

// File: rtl/gser_pkg.sv
package gser_pkg;

    // Default field widths of one frame
    localparam int FINE_BITS  = 5;
    localparam int SLICE_BITS = 4;
    localparam int COARSE_BITS = 16;

    // Line state of the frame shifter
    typedef enum logic {
        LINE_IDLE = 1'b0,
        LINE_SEND = 1'b1
    } line_state_e;

    function automatic int frame_len(input int gray_w, input int fine_w);
        return 1 + gray_w + fine_w;
    endfunction

endpackage

// File: rtl/gser_gray_counter.sv
module gser_gray_counter #(
    parameter int CNT_W = gser_pkg::COARSE_BITS
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] gray_o
);

    logic [CNT_W-1:0] bin_q;

    always_ff @(posedge clk) begin
        if (rst) bin_q <= '0;
        else     bin_q <= bin_q + 1'b1;
    end

    // Binary to Gray, one XOR per bit below the top
    assign gray_o[CNT_W-1] = bin_q[CNT_W-1];
    for (genvar gi = 0; gi < CNT_W-1; gi++) begin : g_xor
        assign gray_o[gi] = bin_q[gi] ^ bin_q[gi+1];
    end

    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R3
    gray_one_step_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> $countones(gray_o ^ $past(gray_o)) == 1);

endmodule

// File: rtl/gser_frame_shifter.sv
module gser_frame_shifter #(
    parameter int FRAME_W = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hit_i,
    input  logic [FRAME_W-1:0] frame_i,
    output logic               ser_o,
    output logic               lost_o
);
    import gser_pkg::*;

    localparam int CNT_W = $clog2(FRAME_W + 1);

    line_state_e        state_q;
    logic [FRAME_W-1:0] shreg_q;
    logic [CNT_W-1:0]   left_q;
    logic               can_take;
    logic               take;

    // Free when idle or on the final bit of the current frame
    assign can_take = (state_q == LINE_IDLE) || (left_q == CNT_W'(1));
    assign take     = hit_i && can_take;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LINE_IDLE;
            shreg_q <= '0;
            left_q  <= '0;
            lost_o  <= 1'b0;
        end else begin
            lost_o <= hit_i && !can_take;
            if (take) begin
                state_q <= LINE_SEND;
                shreg_q <= frame_i;
                left_q  <= CNT_W'(FRAME_W);
            end else if (state_q == LINE_SEND) begin
                shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
                left_q  <= left_q - 1'b1;
                if (left_q == CNT_W'(1)) state_q <= LINE_IDLE;
            end
        end
    end

    assign ser_o = shreg_q[FRAME_W-1];

    // R1
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == LINE_IDLE) |-> !ser_o);

    // R2
    start_bit_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> ser_o);

    // R5
    drop_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_i && state_q == LINE_SEND && left_q != CNT_W'(1)) |=> lost_o);

    // R5
    drop_keeps_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_i && !can_take) |=> (left_q == $past(left_q) - 1'b1));

    // R6
    back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_i && state_q == LINE_SEND && left_q == CNT_W'(1)) |=> (ser_o && !lost_o));

endmodule

// File: rtl/gray_hit_serializer.sv
module gray_hit_serializer #(
    parameter int FINE_W = gser_pkg::FINE_BITS,
    parameter int GRAY_W = gser_pkg::SLICE_BITS,
    parameter int CNT_W  = gser_pkg::COARSE_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit_i,
    input  logic [FINE_W-1:0] fine_i,
    output logic              ser_o,
    output logic              lost_o
);

    localparam int FRAME_W = gser_pkg::frame_len(GRAY_W, FINE_W);

    logic [CNT_W-1:0]   gray_full;
    logic [FRAME_W-1:0] frame;

    gser_gray_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk    (clk),
        .rst    (rst),
        .gray_o (gray_full)
    );

    assign frame = {1'b1, gray_full[GRAY_W-1:0], fine_i};

    gser_frame_shifter #(.FRAME_W(FRAME_W)) i_shift (
        .clk     (clk),
        .rst     (rst),
        .hit_i   (hit_i),
        .frame_i (frame),
        .ser_o   (ser_o),
        .lost_o  (lost_o)
    );

    // R7
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!ser_o && !lost_o));

endmodule

// File: tb/test_gray_hit_serializer.sv
module test_gray_hit_serializer;

    localparam int FW = 5;
    localparam int GW = 4;
    localparam int LEN = 1 + GW + FW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          hit_i = 1'b0;
    logic [FW-1:0] fine_i = '0;
    logic          ser_o;
    logic          lost_o;

    int checks = 0;
    int failures = 0;
    logic [15:0] ref_cnt;

    always #2.5 clk = ~clk;

    gray_hit_serializer i_gray_hit_serializer (
        .clk(clk), .rst(rst), .hit_i(hit_i), .fine_i(fine_i),
        .ser_o(ser_o), .lost_o(lost_o)
    );

    // Cycles since reset, per the requirement text
    always @(posedge clk) ref_cnt <= rst ? 16'd0 : ref_cnt + 16'd1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [LEN-1:0] expect_frame(input logic [15:0] c, input logic [FW-1:0] f);
        logic [15:0] g;
        g = c ^ (c >> 1);
        return {1'b1, g[GW-1:0], f};
    endfunction

    // Present a hit at the current negedge; returns the expected frame
    task automatic launch(input logic [FW-1:0] f, output logic [LEN-1:0] exp);
        hit_i = 1'b1;
        fine_i = f;
        exp = expect_frame(ref_cnt, f);
        @(negedge clk);
        hit_i = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic t_reset_idle();
        for (int k = 0; k < 4; k++) begin
            chk(ser_o == 1'b0, "R1 idle after reset", ser_o, 0);
            chk(lost_o == 1'b0, "R5 no lost at idle", lost_o, 0);
            @(negedge clk);
        end
    endtask

    task automatic t_single(input logic [FW-1:0] f, input int gap);
        logic [LEN-1:0] exp;
        wait_cyc(gap);
        launch(f, exp);
        for (int i = 0; i < LEN; i++) begin
            chk(ser_o == exp[LEN-1-i], (i == 0) ? "R2 start bit" :
                (i <= GW) ? "R3 gray bit" : "R4 fine bit", ser_o, exp[LEN-1-i]);
            chk(lost_o == 1'b0, "R5 lost quiet", lost_o, 0);
            @(negedge clk);
        end
        chk(ser_o == 1'b0, "R1 idle after frame", ser_o, 0);
        chk(ser_o == 1'b0 && lost_o == 1'b0, "R2 frame length", ser_o, 0);
    endtask

    task automatic t_drop();
        logic [LEN-1:0] exp;
        launch(5'b10011, exp);
        for (int i = 0; i < LEN; i++) begin
            if (i == 4) chk(lost_o == 1'b1, "R5 lost pulse", lost_o, 1);
            else        chk(lost_o == 1'b0, "R5 lost single cycle", lost_o, 0);
            chk(ser_o == exp[LEN-1-i], "R5 frame unaffected", ser_o, exp[LEN-1-i]);
            if (i == 3) begin hit_i = 1'b1; fine_i = 5'b01100; end
            @(negedge clk);
            hit_i = 1'b0;
        end
        chk(ser_o == 1'b0, "R5 no frame from dropped hit", ser_o, 0);
    endtask

    task automatic t_back_to_back();
        logic [LEN-1:0] exp1;
        logic [LEN-1:0] exp2;
        launch(5'b11001, exp1);
        for (int i = 0; i < LEN; i++) begin
            chk(ser_o == exp1[LEN-1-i], "R6 first frame", ser_o, exp1[LEN-1-i]);
            if (i == LEN-1) begin
                hit_i = 1'b1; fine_i = 5'b00111;
                exp2 = expect_frame(ref_cnt, 5'b00111);
            end
            @(negedge clk);
            hit_i = 1'b0;
        end
        for (int i = 0; i < LEN; i++) begin
            chk(ser_o == exp2[LEN-1-i], "R6 chained frame", ser_o, exp2[LEN-1-i]);
            chk(lost_o == 1'b0, "R6 chained not lost", lost_o, 0);
            @(negedge clk);
        end
        chk(ser_o == 1'b0, "R1 idle after chain", ser_o, 0);
    endtask

    task automatic t_reset_mid();
        logic [LEN-1:0] exp;
        launch(5'b11111, exp);
        wait_cyc(2);
        rst = 1'b1;
        @(negedge clk);
        chk(ser_o == 1'b0, "R7 reset aborts frame", ser_o, 0);
        chk(lost_o == 1'b0, "R7 reset clears lost", lost_o, 0);
        wait_cyc(2);
        rst = 1'b0;
        wait_cyc(LEN);
        chk(ser_o == 1'b0, "R7 line stays idle", ser_o, 0);
        t_single(5'b01010, 3);
    endtask

    initial begin
        wait_cyc(3);
        rst = 1'b0;
        t_reset_idle();
        t_single(5'b10110, 0);
        t_single(5'b00001, 7);
        t_single(5'b11110, 23);
        t_drop();
        t_back_to_back();
        t_reset_mid();
        t_single(5'b10101, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule